// File: doc/BRIEF.md
# Sequenced PWM Playback Engine

This block drives one pulse-width modulated pin from a short list of 16-bit entries held in a small internal register file. Each entry carries a compare value in its low 15 bits and an inversion flag in bit 15. An up-counting period counter runs from 0 to `cfg_top - 1`, so one PWM period lasts `cfg_top` clocks. Each entry stays on the pin for a programmable number of periods, and then the engine moves to the next entry. The whole list is replayed a programmable number of times. Between playbacks the last entry is stretched by an end delay.

Two termination modes decide how the final playback ends. In stop mode, the final entry stays on the pin for exactly one period. In loop mode, the final entry completes all its repeats. Neither mode applies the end delay after the final playback. When playback ends, the pin returns to a configurable idle level and a one-clock finished pulse is raised.

A typical use is an infrared beacon. The entries alternate between a 50% carrier duty cycle for marks and a constant level for spaces. The repeat count sets the length of each mark or space.

Top module: `pwm_seq_player`

## Requirements
- R1: While reset is held and after it is released, `pwm_out` equals `cfg_idle`, and `busy` and `finished` are low.
- R2: One PWM period lasts `cfg_top` clocks; a `cfg_top` of 0 is treated as 1. The counter value restarts at 0 each period. With entry bit 15 clear, the pin is high while the counter value is below `entry[14:0]` and low for the rest of the period. With bit 15 set, the pin level is inverted. A compare value of 0 gives a constant level, and a compare value of at least `cfg_top` gives the opposite constant level.
- R3: Entries are played in address order starting at 0. Each entry is held for `cfg_repeat + 1` periods.
- R4: Between two playbacks, the last entry is held for `cfg_end_delay` further periods. After that, the list restarts at entry 0.
- R5: The list is played `cfg_plays` times. A `cfg_plays` of 0 ends the request at once, in the same way as R9.
- R6: In stop mode (`cfg_stop_mode` = 1), the last entry of the final playback is held for exactly one period, ignoring both repeats and the end delay.
- R7: In loop mode (`cfg_stop_mode` = 0), the last entry of the final playback is held for all `cfg_repeat + 1` periods, and no end delay follows.
- R8: `busy` rises in the cycle after an accepted `start` and stays high until playback ends. In the clock after the last period, `finished` is high for exactly one cycle, `busy` is low and `pwm_out` is back at `cfg_idle`.
- R9: If `cfg_len` is 0, a start request pulses `finished` in the next cycle, leaves `busy` low and never moves the pin from idle.
- R10: A `start` seen while `busy` is high is ignored, including in the last cycle of playback. Changes to the `cfg_*` inputs other than `cfg_idle` during playback do not affect that playback.
- R11: A value written into the register file during playback reaches the pin only at the next period boundary, never in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register file write strobe |
| wr_addr | input | $clog2(DEPTH) | Register file write address |
| wr_data | input | DW | Entry: bit 15 inverts, bits 14:0 compare value |
| cfg_top | input | DW-1 | Period length in clocks |
| cfg_len | input | $clog2(DEPTH+1) | Number of list entries, 0 to DEPTH |
| cfg_repeat | input | REP_W | Extra periods per entry |
| cfg_end_delay | input | DLY_W | Extra periods of last entry between playbacks |
| cfg_plays | input | PLAY_W | Number of list playbacks |
| cfg_stop_mode | input | 1 | 1 = stop mode, 0 = loop mode |
| cfg_idle | input | 1 | Pin level while not playing |
| start | input | 1 | Playback request |
| pwm_out | output | 1 | PWM pin |
| busy | output | 1 | Playback in progress |
| finished | output | 1 | One-cycle end-of-playback pulse |

## Verification
Two events can land on the same clock edge: the final period boundary that ends playback, and a fresh `start` request. The bench raises `start` during the last cycle of a run. It then checks that `finished` pulses once, that `busy` falls and stays low, and that the pin stays at idle afterwards. A second `start`, raised together with scrambled configuration halfway through a run, checks that neither input disturbs the expected waveform.

The same boundary also coincides with a list advance, a replay wrap, or entry into the end delay. The bench tests these with random list lengths, repeat counts, delays and both modes. Every clock of the pin is compared against a per-period schedule built from the requirements.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [0:0] {
    PH_VAL = 1'b0,
    PH_DLY = 1'b1
  } phase_t;

  typedef enum logic [2:0] {
    ACT_HOLD   = 3'd0,
    ACT_REP    = 3'd1,
    ACT_NEXT   = 3'd2,
    ACT_DELAY  = 3'd3,
    ACT_DCNT   = 3'd4,
    ACT_REPLAY = 3'd5,
    ACT_END    = 3'd6
  } act_t;
endpackage

// File: rtl/pwm_entry_mem.sv
module pwm_entry_mem #(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [$clog2(DEPTH)-1:0]   waddr,
  input  logic [DW-1:0]              wdata,
  input  logic [$clog2(DEPTH)-1:0]   raddr,
  output logic [DW-1:0]              rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // small distributed array: read is combinational, latched at boundaries
  assign rdata = store[raddr];
endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt_nxt,
  output logic          wrap
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] top_l;

  assign wrap = run && (cnt == top_l - CW'(1));

  always_comb begin
    if (!run || wrap) cnt_nxt = '0;
    else              cnt_nxt = cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      top_l <= CW'(1);
    end else begin
      cnt <= cnt_nxt;
      if (!run) top_l <= (top == '0) ? CW'(1) : top;
    end
  end

  AST_CNT_BELOW_TOP: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < top_l)); // R2

  AST_TOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    run && $past(run) |-> $stable(top_l)); // R10
endmodule

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
  import pwm_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int REP_W  = 8,
  parameter int DLY_W  = 8,
  parameter int PLAY_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         stop_mode,
  input  logic [$clog2(DEPTH+1)-1:0]   len,
  input  logic [REP_W-1:0]             rep,
  input  logic [DLY_W-1:0]             dly,
  input  logic [PLAY_W-1:0]            plays,
  input  logic                         wrap,
  output logic                         busy,
  output logic                         finished,
  output logic                         run_nxt,
  output logic                         load,
  output logic [$clog2(DEPTH)-1:0]     idx_nxt
);
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam int AW    = $clog2(DEPTH);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

  logic [LEN_W-1:0]  len_l, idx_r, idx_w;
  logic [REP_W-1:0]  rep_l, rep_c;
  logic [DLY_W-1:0]  dly_l, dly_c;
  logic [PLAY_W-1:0] plays_l, play_c;
  logic              stop_l;
  phase_t            phase;
  act_t              act;
  logic              accept, empty, last_entry, final_play;

  assign accept     = start && !busy;
  assign empty      = (len == '0) || (plays == '0);
  assign last_entry = (idx_r == len_l - LEN_W'(1));
  assign final_play = (play_c == plays_l - PLAY_W'(1));

  always_comb begin
    act = ACT_HOLD;
    if (busy && wrap) begin
      if (phase == PH_DLY)
        act = (dly_c == dly_l - DLY_W'(1)) ? ACT_REPLAY : ACT_DCNT;
      else if (stop_l && final_play && last_entry) act = ACT_END;
      else if (rep_c != rep_l)                     act = ACT_REP;
      else if (!last_entry)                        act = ACT_NEXT;
      else if (final_play)                         act = ACT_END;
      else if (dly_l != '0)                        act = ACT_DELAY;
      else                                         act = ACT_REPLAY;
    end
  end

  always_comb begin
    if (accept)                  idx_w = '0;
    else if (act == ACT_NEXT)    idx_w = idx_r + LEN_W'(1);
    else if (act == ACT_REPLAY)  idx_w = '0;
    else                         idx_w = idx_r;
  end

  assign idx_nxt = idx_w[AW-1:0];
  assign run_nxt = (accept && !empty) || (busy && (act != ACT_END));
  assign load    = (accept && !empty) || (busy && wrap && (act != ACT_END));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      finished <= 1'b0;
      idx_r    <= '0;
      rep_c    <= '0;
      dly_c    <= '0;
      play_c   <= '0;
      phase    <= PH_VAL;
      len_l    <= '0;
      rep_l    <= '0;
      dly_l    <= '0;
      plays_l  <= '0;
      stop_l   <= 1'b0;
    end else begin
      finished <= (accept && empty) || (act == ACT_END);
      busy     <= run_nxt;
      idx_r    <= idx_w;
      if (accept) begin
        len_l   <= (len > DEPTH_L) ? DEPTH_L : len;
        rep_l   <= rep;
        dly_l   <= dly;
        plays_l <= plays;
        stop_l  <= stop_mode;
        rep_c   <= '0;
        dly_c   <= '0;
        play_c  <= '0;
        phase   <= PH_VAL;
      end else begin
        case (act)
          ACT_REP:   rep_c <= rep_c + REP_W'(1);
          ACT_NEXT:  rep_c <= '0;
          ACT_DELAY: begin
            phase <= PH_DLY;
            dly_c <= '0;
          end
          ACT_DCNT:  dly_c <= dly_c + DLY_W'(1);
          ACT_REPLAY: begin
            phase  <= PH_VAL;
            rep_c  <= '0;
            dly_c  <= '0;
            play_c <= play_c + PLAY_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  AST_FIN_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    finished |-> !busy); // R8

  AST_BUSY_FALL_FIN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> finished); // R8

  AST_IDX_IN_LIST: assert property (@(posedge clk) disable iff (rst)
    busy |-> (idx_r < len_l)); // R3

  AST_PLAY_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (play_c < plays_l)); // R5

  AST_DELAY_NOT_FINAL: assert property (@(posedge clk) disable iff (rst)
    busy && (phase == PH_DLY) |-> !final_play); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(len_l) && $stable(rep_l) && $stable(stop_l)); // R10
endmodule

// File: rtl/pwm_seq_player.sv
module pwm_seq_player #(
  parameter int DEPTH  = 32,
  parameter int DW     = 16,
  parameter int REP_W  = 8,
  parameter int DLY_W  = 8,
  parameter int PLAY_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [$clog2(DEPTH)-1:0]    wr_addr,
  input  logic [DW-1:0]               wr_data,
  input  logic [DW-2:0]               cfg_top,
  input  logic [$clog2(DEPTH+1)-1:0]  cfg_len,
  input  logic [REP_W-1:0]            cfg_repeat,
  input  logic [DLY_W-1:0]            cfg_end_delay,
  input  logic [PLAY_W-1:0]           cfg_plays,
  input  logic                        cfg_stop_mode,
  input  logic                        cfg_idle,
  input  logic                        start,
  output logic                        pwm_out,
  output logic                        busy,
  output logic                        finished
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = DW - 1;

  logic          busy_q, run_nxt, load, wrap, out_q;
  logic [AW-1:0] idx_nxt;
  logic [DW-1:0] rdata, cur, cur_nxt;
  logic [CW-1:0] cnt_nxt;

  pwm_entry_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (idx_nxt),
    .rdata (rdata)
  );

  pwm_period_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .run     (busy_q),
    .top     (cfg_top),
    .cnt_nxt (cnt_nxt),
    .wrap    (wrap)
  );

  pwm_seq_ctrl #(
    .DEPTH(DEPTH), .REP_W(REP_W), .DLY_W(DLY_W), .PLAY_W(PLAY_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stop_mode (cfg_stop_mode),
    .len       (cfg_len),
    .rep       (cfg_repeat),
    .dly       (cfg_end_delay),
    .plays     (cfg_plays),
    .wrap      (wrap),
    .busy      (busy_q),
    .finished  (finished),
    .run_nxt   (run_nxt),
    .load      (load),
    .idx_nxt   (idx_nxt)
  );

  assign cur_nxt = load ? rdata : cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      out_q <= cfg_idle;
    end else begin
      cur   <= cur_nxt;
      out_q <= run_nxt ? ((cnt_nxt < cur_nxt[CW-1:0]) ^ cur_nxt[DW-1]) : cfg_idle;
    end
  end

  assign pwm_out = out_q;
  assign busy    = busy_q;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (pwm_out == $past(cfg_idle))); // R8

  AST_LOAD_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    busy_q && !$stable(cur) |-> ($past(wrap) || !$past(busy_q))); // R11
endmodule

// File: tb/test_pwm_seq_player.sv
`timescale 1ns/1ps
module test_pwm_seq_player;
  localparam int DEPTH = 32;
  localparam int DW    = 16;
  localparam int MAXP  = 512;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [15:0] wr_data;
  logic [14:0] cfg_top;
  logic [5:0]  cfg_len;
  logic [7:0]  cfg_repeat, cfg_end_delay, cfg_plays;
  logic        cfg_stop_mode, cfg_idle, start;
  logic        pwm_out, busy, finished;

  int n_chk  = 0;
  int n_fail = 0;
  logic [15:0] sh [DEPTH];
  logic [15:0] per_val [MAXP];
  int np;

  always #2 clk = ~clk;

  pwm_seq_player i_pwm_seq_player (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_top(cfg_top), .cfg_len(cfg_len), .cfg_repeat(cfg_repeat),
    .cfg_end_delay(cfg_end_delay), .cfg_plays(cfg_plays),
    .cfg_stop_mode(cfg_stop_mode), .cfg_idle(cfg_idle), .start(start),
    .pwm_out(pwm_out), .busy(busy), .finished(finished)
  );

  function automatic bit exp_bit(input int cnt, input logic [15:0] e);
    return ((cnt < int'(e[14:0])) ? 1'b1 : 1'b0) ^ e[15];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d; sh[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // period schedule from R3, R4, R5, R6, R7
  task automatic build(input int ln, input int rp, input int dl, input int pl, input bit stp);
    np = 0;
    for (int p = 0; p < pl; p++) begin
      for (int i = 0; i < ln; i++) begin
        int k;
        k = (stp && p == pl - 1 && i == ln - 1) ? 1 : rp + 1;
        for (int r = 0; r < k; r++) begin per_val[np] = sh[i]; np++; end
      end
      if (p != pl - 1)
        for (int r = 0; r < dl; r++) begin per_val[np] = sh[ln-1]; np++; end
    end
  endtask

  task automatic run_seq(input int ln, input int rp, input int dl, input int pl,
                         input bit stp, input int tp, input bit idl, input bit poke,
                         input int wr_at, input logic [15:0] wr_val, input string tag);
    int tot, tpe;
    cfg_len = 6'(ln); cfg_repeat = 8'(rp); cfg_end_delay = 8'(dl);
    cfg_plays = 8'(pl); cfg_stop_mode = stp; cfg_top = 15'(tp); cfg_idle = idl;
    tpe = (tp == 0) ? 1 : tp;
    build(ln, rp, dl, pl, stp);
    if (wr_at >= 0)
      for (int q = wr_at / tpe + 1; q < np; q++) per_val[q] = wr_val;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      cfg_len = 6'd2; cfg_repeat = 8'd0; cfg_end_delay = 8'd5;
      cfg_plays = 8'd7; cfg_stop_mode = ~stp; cfg_top = 15'd3;
    end
    tot = np * tpe;
    for (int j = 0; j < tot; j++) begin
      bit e;
      if (j > 0) @(negedge clk);
      wr_en = 1'b0;
      e = exp_bit(j % tpe, per_val[j / tpe]);
      chk(pwm_out == e, tag, int'(pwm_out), int'(e));
      chk(busy == 1'b1, "R8 busy during playback", int'(busy), 1);
      chk(finished == 1'b0, "R8 no early finished", int'(finished), 0);
      start = poke && (j == tot / 2 || j == tot - 1);  // R10 ignored start
      if (j == wr_at) begin
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = wr_val; sh[0] = wr_val;
      end
    end
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    chk(finished == 1'b1, "R8 finished pulse", int'(finished), 1);
    chk(busy == 1'b0, "R8 busy low at end", int'(busy), 0);
    chk(pwm_out == idl, "R8 idle after end", int'(pwm_out), int'(idl));
    @(negedge clk);
    chk(finished == 1'b0, "R10 finished single, no restart", int'(finished), 0);
    chk(busy == 1'b0, "R10 start at end ignored", int'(busy), 0);
    chk(pwm_out == idl, "R10 pin stays idle", int'(pwm_out), int'(idl));
  endtask

  task automatic empty_req(input int ln, input int pl, input bit idl, input string tag);
    cfg_len = 6'(ln); cfg_plays = 8'(pl); cfg_idle = idl;
    cfg_repeat = 8'd1; cfg_top = 15'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(finished == 1'b1, tag, int'(finished), 1);
    chk(busy == 1'b0, tag, int'(busy), 0);
    chk(pwm_out == idl, tag, int'(pwm_out), int'(idl));
    @(negedge clk);
    chk(finished == 1'b0, tag, int'(finished), 0);
    chk(pwm_out == idl, tag, int'(pwm_out), int'(idl));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20251));
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; start = 1'b0;
    cfg_top = 15'd4; cfg_len = 6'd1; cfg_repeat = '0; cfg_end_delay = '0;
    cfg_plays = 8'd1; cfg_stop_mode = 1'b0; cfg_idle = 1'b1;
    for (int i = 0; i < DEPTH; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b1, "R1 idle in reset", int'(pwm_out), 1);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b1, "R1 idle after reset", int'(pwm_out), 1);
    chk(finished == 1'b0, "R1 finished after reset", int'(finished), 0);
    for (int i = 0; i < DEPTH; i++) put(i, 16'h0000);

    // R9 empty list, R5 zero plays
    empty_req(0, 2, 1'b1, "R9 zero length");
    empty_req(3, 0, 1'b0, "R5 zero plays");

    // R2 duty extremes and inversion
    put(0, 16'h0000); put(1, 16'h0007); put(2, 16'h8003); put(3, 16'h0003); put(4, 16'h8000);
    run_seq(5, 0, 0, 1, 1'b0, 5, 1'b0, 1'b0, -1, '0, "R2 duty and inversion");
    run_seq(1, 0, 0, 1, 1'b0, 0, 1'b1, 1'b0, -1, '0, "R2 top zero as one");

    // R6 vs R7 with delay between playbacks (R4)
    put(0, 16'h0002); put(1, 16'h8001); put(2, 16'h0003);
    run_seq(3, 2, 2, 2, 1'b1, 4, 1'b1, 1'b0, -1, '0, "R6 stop mode R4 delay");
    run_seq(3, 2, 2, 2, 1'b0, 4, 1'b1, 1'b0, -1, '0, "R7 loop mode R4 delay");
    run_seq(3, 1, 0, 3, 1'b0, 3, 1'b0, 1'b0, -1, '0, "R5 three plays R3 hold");

    // R10 start and config changes during playback, start in last cycle
    run_seq(3, 1, 1, 2, 1'b0, 4, 1'b1, 1'b1, -1, '0, "R10 poke during playback");

    // R11 write mid-period takes effect at next boundary
    put(0, 16'h0002);
    run_seq(1, 3, 0, 1, 1'b0, 8, 1'b0, 1'b0, 10, 16'h0006, "R11 write at boundary");

    // random runs
    for (int v = 0; v < 40; v++) begin
      int ln, rp, dl, pl, tp;
      bit stp, idl, pk;
      ln  = 1 + int'($urandom % 6);
      rp  = int'($urandom % 4);
      dl  = int'($urandom % 4);
      pl  = 1 + int'($urandom % 3);
      tp  = 2 + int'($urandom % 8);
      stp = 1'($urandom % 2);
      idl = 1'($urandom % 2);
      pk  = ($urandom % 4) == 0;
      for (int i = 0; i < ln; i++)
        put(i, {1'($urandom % 2), 15'($urandom % 11)});
      run_seq(ln, rp, dl, pl, stp, tp, idl, pk, -1, '0,
              stp ? "R3/R6 random stop" : "R3/R7 random loop");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule